// File: doc/BRIEF.md
# Six-Channel DMA Burst Arbiter

This block chooses which of six DMA channels runs its burst next. Each channel provides an enable bit and a request bit. A channel is eligible when both are high. The arbiter grants one channel at a time and keeps that grant until the engine reports end of burst. Data movement and address generation stay outside the block. The engine and the arbiter exchange only a one-hot grant, a burst-word boundary pulse and a burst-done pulse.

By default the arbiter rotates among eligible channels. A configuration input places channel 1 in high-priority mode. In that mode a channel-1 request can suspend a lower channel's burst at a word boundary, and the suspended burst resumes once channel 1 finishes. A priority-reset control accepts a write of 1, which requests a fresh start of the rotation. That request waits until every burst, including a suspended one, has drained.

Grant bit i corresponds to channel i+1, so bit 0 is channel 1 and bit 5 is channel 6.

Top module: `dma_burst_arbiter`

## Requirements
- R1: After synchronous reset, no grant is active, no burst is suspended, no priority reset is pending, and the rotation pointer selects channel 1 (grant bit 0).
- R2: At most one bit of `grant` is high in any cycle.
- R3: Outside high-priority mode, a granted channel keeps its grant unchanged until `burst_done` is seen.
- R4: In rotation, the search for the next grant starts at the channel after the one granted last by rotation. The search wraps from channel 6 to channel 1 and skips channels that are not both enabled and requesting.
- R5: When `burst_done` is seen, the grant moves to the next eligible channel in the following cycle. That channel may be the same one if it is next in turn. If no channel is eligible, all grant bits go low.
- R6: In high-priority mode, suppose a lower channel holds the grant, `word_done` is high, `burst_done` is low, channel 1 is eligible, and no priority reset is pending. The grant then moves to channel 1 in the next cycle, and the interrupted channel is recorded as suspended.
- R7: When channel 1 finishes while a burst is suspended, the suspended channel gets the grant back in the next cycle. This takes precedence over any other request, and the resume does not move the rotation pointer.
- R8: A write with data 0 on the priority-reset control has no effect, and `prio_reset_rdata` always reads 0.
- R9: A write of 1 latches a pending priority reset. Bursts in progress, including a suspended one, are allowed to finish. Once no burst remains, one cycle passes with no grant while the pointer reloads. The rotation then restarts from channel 1.
- R10: A channel disabled while it holds the grant keeps the grant until its `burst_done`, and it is not granted again while disabled.
- R11: In high-priority mode, an eligible channel 1 wins over all rotating channels whenever the grant is free. Channel 1 takes no part in the rotation.
- R12: In high-priority mode, a priority reset restarts the rotation from channel 2, or from the next eligible channel above it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ch_enable | input | 6 | Per-channel enable, bit i = channel i+1 |
| ch_request | input | 6 | Per-channel pending request, bit i = channel i+1 |
| hi_pri_ch1 | input | 1 | Channel 1 high-priority mode |
| prio_reset_wr | input | 1 | Write strobe for the priority-reset control |
| prio_reset_wdata | input | 1 | Data bit written to the priority-reset control |
| word_done | input | 1 | Burst-word boundary pulse from the engine |
| burst_done | input | 1 | End of the granted channel's burst |
| grant | output | 6 | One-hot grant, bit i = channel i+1 |
| prio_reset_rdata | output | 1 | Read-back of the priority-reset control (always 0) |

## Verification
The assertions check four behaviours on every cycle: that the grant is one-hot or idle, that it stays put during a burst in rotation mode, that pre-emption and resume hand over the grant within one cycle, and that a pending priority reset issues no grant while idle. Some behaviours depend on history and are shown only by the bench's scenarios. These are the rotation order with wrap-around and skipping, the pointer position after a resume, the exclusion of a channel disabled mid-burst, the ignored write of 0, and the restart channel after a deferred priority reset in both modes.

// File: rtl/dma_arb_pkg.sv
// Package: shared types for the DMA burst arbiter.
// Assumes: used by dma_burst_arbiter and its sub-blocks only.
package dma_arb_pkg;

    // Source of the grant chosen when the grant slot is free
    typedef enum logic [1:0] {
        SRC_NONE   = 2'd0,
        SRC_RESUME = 2'd1,
        SRC_HIPRI  = 2'd2,
        SRC_ROTATE = 2'd3
    } grant_src_e;

endpackage

// File: rtl/dma_arb_rr_pick.sv
// Module: dma_arb_rr_pick
// Finds the first set bit of `elig`, starting at index `start` and wrapping.
// Assumes: start < NUM_CH. Purely combinational.
module dma_arb_rr_pick #(
    parameter int NUM_CH = 6,
    localparam int IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic [NUM_CH-1:0] elig,
    input  logic [IDX_W-1:0]  start,
    output logic              hit,
    output logic [IDX_W-1:0]  sel
);

    // Scan offsets from far to near so the nearest eligible index wins
    always_comb begin : scan
        int j;
        hit = 1'b0;
        sel = '0;
        for (int k = NUM_CH - 1; k >= 0; k--) begin
            j = (int'(start) + k) % NUM_CH;
            if (elig[j]) begin
                hit = 1'b1;
                sel = IDX_W'(j);
            end
        end
    end

endmodule

// File: rtl/dma_arb_prio_reset.sv
// Module: dma_arb_prio_reset
// Holds a deferred priority-reset request. A write of 1 sets it. A write of 0
// does nothing. It clears when the arbiter reloads its pointer (R8, R9).
// Assumes: a new write in the reload cycle wins over the clear.
module dma_arb_prio_reset (
    input  logic clk,
    input  logic rst_n,
    input  logic wr,
    input  logic wdata,
    input  logic reload,
    output logic pending
);

    // Pending flag: set on write-one, cleared on reload
    always_ff @(posedge clk) begin
        if (!rst_n)
            pending <= 1'b0;
        else if (wr && wdata)
            pending <= 1'b1;
        else if (reload)
            pending <= 1'b0;
    end

endmodule

// File: rtl/dma_burst_arbiter.sv
// Module: dma_burst_arbiter
// Grants one DMA channel's burst at a time. It rotates among enabled,
// requesting channels, with an optional pre-emptive high-priority channel 1
// and a deferred restart of the rotation.
// Assumes: burst_done and word_done refer to the currently granted channel.
// Grant bit i is channel i+1.
module dma_burst_arbiter #(
    parameter int NUM_CH = 6,
    localparam int IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] ch_enable,
    input  logic [NUM_CH-1:0] ch_request,
    input  logic              hi_pri_ch1,
    input  logic              prio_reset_wr,
    input  logic              prio_reset_wdata,
    input  logic              word_done,
    input  logic              burst_done,
    output logic [NUM_CH-1:0] grant,
    output logic              prio_reset_rdata
);
    import dma_arb_pkg::*;

    localparam logic [IDX_W-1:0] LAST_IDX  = IDX_W'(NUM_CH - 1);
    localparam logic [IDX_W-1:0] FIRST_IDX = '0;
    localparam logic [IDX_W-1:0] HI_START  = IDX_W'(1);

    logic              act_v;
    logic [IDX_W-1:0]  act_ch;
    logic              susp_v;
    logic [IDX_W-1:0]  susp_ch;
    logic [IDX_W-1:0]  rr_ptr;
    logic              prio_pend;

    logic [NUM_CH-1:0] elig;
    logic [NUM_CH-1:0] rr_elig;
    logic              rr_hit;
    logic [IDX_W-1:0]  rr_sel;
    logic [IDX_W-1:0]  rr_next;
    logic              slot_free;
    logic              preempt;
    logic              reload;
    grant_src_e        src;

    // Eligibility: enabled and requesting; channel 1 leaves the rotation in high-priority mode (R11)
    always_comb begin
        elig    = ch_enable & ch_request;
        rr_elig = elig & {{(NUM_CH-1){1'b1}}, ~hi_pri_ch1};
    end

    dma_arb_rr_pick #(.NUM_CH(NUM_CH)) u_pick (
        .elig  (rr_elig),
        .start (rr_ptr),
        .hit   (rr_hit),
        .sel   (rr_sel)
    );

    dma_arb_prio_reset u_prst (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (prio_reset_wr),
        .wdata   (prio_reset_wdata),
        .reload  (reload),
        .pending (prio_pend)
    );

    // Pointer value after a rotation grant: the channel after the granted one, wrapping (R4)
    always_comb rr_next = (rr_sel == LAST_IDX) ? FIRST_IDX : rr_sel + 1'b1;

    // Grant decision: resume, then reset drain, then channel 1, then rotation (R5, R7, R9)
    always_comb begin
        slot_free = !act_v || burst_done;
        src       = SRC_NONE;
        reload    = 1'b0;
        if (slot_free) begin
            if (susp_v)
                src = SRC_RESUME;
            else if (prio_pend)
                reload = 1'b1;
            else if (hi_pri_ch1 && elig[0])
                src = SRC_HIPRI;
            else if (rr_hit)
                src = SRC_ROTATE;
        end
        preempt = !slot_free && hi_pri_ch1 && (act_ch != FIRST_IDX) && word_done
                  && elig[0] && !prio_pend && !susp_v;
    end

    // Arbitration state: active grant, suspended burst and rotation pointer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_v   <= 1'b0;
            act_ch  <= '0;
            susp_v  <= 1'b0;
            susp_ch <= '0;
            rr_ptr  <= FIRST_IDX;
        end else if (preempt) begin
            susp_v  <= 1'b1;
            susp_ch <= act_ch;
            act_ch  <= FIRST_IDX;
        end else if (slot_free) begin
            unique case (src)
                SRC_RESUME: begin
                    act_v  <= 1'b1;
                    act_ch <= susp_ch;
                    susp_v <= 1'b0;
                end
                SRC_HIPRI: begin
                    act_v  <= 1'b1;
                    act_ch <= FIRST_IDX;
                end
                SRC_ROTATE: begin
                    act_v  <= 1'b1;
                    act_ch <= rr_sel;
                    rr_ptr <= rr_next;
                end
                default: act_v <= 1'b0;
            endcase
            if (reload)
                rr_ptr <= hi_pri_ch1 ? HI_START : FIRST_IDX;
        end
    end

    // One-hot grant decode from the active channel index (R2)
    for (genvar i = 0; i < NUM_CH; i++) begin : g_grant
        assign grant[i] = act_v && (act_ch == IDX_W'(i));
    end

    // The priority-reset control is write-only in effect (R8)
    assign prio_reset_rdata = 1'b0;

endmodule

// File: rtl/dma_burst_arbiter_chk.sv
// Module: dma_burst_arbiter_chk
// Cycle-by-cycle properties of the arbiter, attached with bind.
// Assumes: internal pending and suspend state are connected by the bind.
module dma_burst_arbiter_chk #(
    parameter int NUM_CH = 6,
    parameter int IDX_W  = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NUM_CH-1:0] grant,
    input logic [NUM_CH-1:0] ch_enable,
    input logic [NUM_CH-1:0] ch_request,
    input logic              hi_pri_ch1,
    input logic              word_done,
    input logic              burst_done,
    input logic              pend,
    input logic              susp_v,
    input logic [IDX_W-1:0]  susp_ch
);

    // R2: never two grants at once
    p_onehot_grant_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    // R3: rotation grant held until burst end
    p_hold_grant_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (grant != '0 && !burst_done && !hi_pri_ch1) |=> (grant == $past(grant)));

    // R6: pre-emption hands the grant to channel 1
    p_preempt_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (hi_pri_ch1 && grant != '0 && !grant[0] && !burst_done && word_done
         && ch_enable[0] && ch_request[0] && !pend && !susp_v)
        |=> (grant == NUM_CH'(1)));

    // R7: suspended burst resumes right after channel 1 ends
    p_resume_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (susp_v && grant[0] && burst_done) |=> (grant == (NUM_CH'(1) << $past(susp_ch))));

    // R9: with a reset pending and nothing granted, nothing is granted next
    p_drain_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && grant == '0) |=> (grant == '0));

endmodule

bind dma_burst_arbiter dma_burst_arbiter_chk #(.NUM_CH(NUM_CH), .IDX_W(IDX_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .grant      (grant),
    .ch_enable  (ch_enable),
    .ch_request (ch_request),
    .hi_pri_ch1 (hi_pri_ch1),
    .word_done  (word_done),
    .burst_done (burst_done),
    .pend       (prio_pend),
    .susp_v     (susp_v),
    .susp_ch    (susp_ch)
);

// File: tb/dma_burst_arbiter_bench.sv
// Bench: scoreboard for dma_burst_arbiter. The driver queues the expected
// grant for each driven cycle. The monitor pops and compares after each edge.
module dma_burst_arbiter_bench;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [5:0] ch_enable;
    logic [5:0] ch_request;
    logic       hi_pri_ch1;
    logic       prio_reset_wr;
    logic       prio_reset_wdata;
    logic       word_done;
    logic       burst_done;
    logic [5:0] grant;
    logic       prio_reset_rdata;

    int n_cmp  = 0;
    int n_bad  = 0;
    bit done_f = 1'b0;

    typedef struct {
        logic [5:0] g;
        string      tag;
    } exp_t;
    exp_t q[$];

    dma_burst_arbiter u_dma_burst_arbiter (
        .clk              (clk),
        .rst_n            (rst_n),
        .ch_enable        (ch_enable),
        .ch_request       (ch_request),
        .hi_pri_ch1       (hi_pri_ch1),
        .prio_reset_wr    (prio_reset_wr),
        .prio_reset_wdata (prio_reset_wdata),
        .word_done        (word_done),
        .burst_done       (burst_done),
        .grant            (grant),
        .prio_reset_rdata (prio_reset_rdata)
    );

    always #5 clk = ~clk;

    // Drive one cycle of stimulus at the falling edge and queue the grant expected after the next rising edge
    task automatic drive(input logic [5:0] en, input logic [5:0] req, input logic wd,
                         input logic bd, input logic hi, input logic prw, input logic prd,
                         input logic [5:0] eg, input string tag);
        @(negedge clk);
        ch_enable        = en;
        ch_request       = req;
        word_done        = wd;
        burst_done       = bd;
        hi_pri_ch1       = hi;
        prio_reset_wr    = prw;
        prio_reset_wdata = prd;
        q.push_back('{g: eg, tag: tag});
    endtask

    // Monitor: compare grant and read-back after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                n_cmp++;
                if (grant !== e.g || prio_reset_rdata !== 1'b0) begin
                    n_bad++;
                    $display("FAIL %s: grant=%b rdata=%b expected grant=%b rdata=0",
                             e.tag, grant, prio_reset_rdata, e.g);
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure
    initial begin
        #1_000_000;
        if (!done_f) begin
            n_bad++;
            n_cmp++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        ch_enable = '0; ch_request = '0; hi_pri_ch1 = 1'b0;
        prio_reset_wr = 1'b0; prio_reset_wdata = 1'b0;
        word_done = 1'b0; burst_done = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        n_cmp++;
        if (grant !== 6'b0 || prio_reset_rdata !== 1'b0) begin
            n_bad++;
            $display("FAIL R1 reset: grant=%b rdata=%b expected 000000 0", grant, prio_reset_rdata);
        end
        rst_n = 1'b1;

        // Rotation mode
        drive(6'h3F, 6'b000100, 0, 0, 0, 0, 0, 6'b000100, "R1 first grant from pointer at ch1");
        drive(6'h3F, 6'b101101, 0, 0, 0, 0, 0, 6'b000100, "R3 hold during burst");
        drive(6'h3F, 6'b101101, 0, 1, 0, 0, 0, 6'b001000, "R4 next after ch3");
        drive(6'h3F, 6'b101101, 0, 1, 0, 0, 0, 6'b100000, "R4 skip ch5");
        drive(6'h3F, 6'b101101, 0, 1, 0, 0, 0, 6'b000001, "R4 wrap to ch1");
        drive(6'h3F, 6'b101101, 0, 1, 0, 0, 0, 6'b000100, "R4 skip ch2");
        drive(6'h3F, 6'b000100, 0, 1, 0, 0, 0, 6'b000100, "R5 same channel again");
        drive(6'h3F, 6'b000000, 0, 1, 0, 0, 0, 6'b000000, "R5 deassert when none");
        drive(6'h3F, 6'b000000, 0, 0, 0, 0, 0, 6'b000000, "R5 idle");

        // Disable while granted
        drive(6'h3F, 6'b010000, 0, 0, 0, 0, 0, 6'b010000, "R10 grant ch5");
        drive(6'h2F, 6'b010000, 0, 0, 0, 0, 0, 6'b010000, "R10 keep after disable");
        drive(6'h2F, 6'b010000, 0, 1, 0, 0, 0, 6'b000000, "R10 excluded after burst");
        drive(6'h3F, 6'b000000, 0, 0, 0, 0, 0, 6'b000000, "R10 idle");

        // Priority reset, rotation mode (pointer at ch6)
        drive(6'h3F, 6'b000000, 0, 0, 0, 1, 0, 6'b000000, "R8 write zero");
        drive(6'h3F, 6'b100001, 0, 0, 0, 0, 0, 6'b100000, "R8 write zero ignored");
        drive(6'h3F, 6'b000010, 0, 1, 0, 0, 0, 6'b000010, "R4 grant ch2");
        drive(6'h3F, 6'b100011, 0, 0, 0, 1, 1, 6'b000010, "R9 burst not cut");
        drive(6'h3F, 6'b100011, 0, 1, 0, 0, 0, 6'b000000, "R9 reload cycle no grant");
        drive(6'h3F, 6'b100011, 0, 0, 0, 0, 0, 6'b000001, "R9 restart from ch1");
        drive(6'h3F, 6'b000000, 0, 1, 0, 0, 0, 6'b000000, "R9 idle");

        // High-priority channel 1 (pointer at ch2)
        drive(6'h3F, 6'b000101, 0, 0, 1, 0, 0, 6'b000001, "R11 ch1 wins over rotation");
        drive(6'h3F, 6'b000100, 0, 1, 1, 0, 0, 6'b000100, "R11 rotation grant ch3");
        drive(6'h3F, 6'b000101, 1, 0, 1, 0, 0, 6'b000001, "R6 preempt at word boundary");
        drive(6'h3F, 6'b000101, 0, 0, 1, 0, 0, 6'b000001, "R6 ch1 holds");
        drive(6'h3F, 6'b001101, 0, 1, 1, 0, 0, 6'b000100, "R7 resume ch3");
        drive(6'h3F, 6'b001000, 0, 1, 1, 0, 0, 6'b001000, "R7 pointer untouched by resume");

        // High-priority mode with deferred reset (pointer at ch5)
        drive(6'h3F, 6'b001001, 1, 0, 1, 0, 0, 6'b000001, "R6 preempt ch4");
        drive(6'h3F, 6'b001001, 0, 0, 1, 1, 1, 6'b000001, "R9 ch1 burst not cut");
        drive(6'h3F, 6'b001001, 0, 1, 1, 0, 0, 6'b001000, "R9 suspended burst drains");
        drive(6'h3F, 6'b100011, 0, 1, 1, 0, 0, 6'b000000, "R12 reload cycle no grant");
        drive(6'h3F, 6'b100010, 0, 0, 1, 0, 0, 6'b000010, "R12 restart from ch2");
        drive(6'h3F, 6'b000000, 0, 1, 1, 0, 0, 6'b000000, "R12 idle");

        repeat (3) @(posedge clk);
        #2;
        done_f = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule